// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers up to seventeen level-high serial interrupt lines into a single interrupt output. It does so through two stacked stages of sticky status. The first stage is a host-controller stage. A line that is high on a clock edge sets its own status bit there, and the bit stays set until software writes a one to it. The stage then combines that status with a mask and a global enable bit into one summary signal. That summary appears as a single fixed input bit of the second stage, which is a bus-master interrupt stage. There, the input is masked and collected into a second sticky status register, and any set bit there drives `irq_out`.

Software reaches both stages through one 32-bit register port with byte offsets. Only aligned 4-byte accesses take effect. The port accepts one access on every cycle and applies no back-pressure. A read returns its data one cycle later together with `rsp_valid`, and the response cannot be stalled. The design re-evaluates every cycle, so the result after a register write or a line event matches an evaluation run right after that write or event. Status registers update on the clock edge. The summary, the second-stage input and `irq_out` follow combinationally from the registered state.

Top module: `irq_latch_aggr`

## Requirements
- R1: After reset every register reads zero, except offset 0x28, which reads 0x02000000. `irq_out` and `rsp_valid` are low.
- R2: When line n (0 to 16) of `sirq_lvl` is high at a clock edge, bit (31 - n) of the host status at 0x38 is set from that edge on. The bit stays set after the line drops.
- R3: A write to 0x38 clears each status bit written as one and leaves the others. If a line sets a bit in the same cycle that a write clears it, the set wins.
- R4: The host summary is high only when bit 31 of the control register at 0x30 is one and (host status AND host mask at 0x34) is nonzero. The summary reads as bit 11 of the master input register at 0x5C. Every other bit of 0x5C reads zero.
- R5: Writes to 0x40 and to 0x5C have no effect. 0x40 always reads zero.
- R6: On every edge, the master status at 0x50 takes on (input AND master mask at 0x54). Its bits stay set after the input drops. A write to 0x50 clears the bits written as one, but a bit whose masked input is still high is set again at that same edge.
- R7: `irq_out` is high exactly when the master status is nonzero. A line event therefore reaches `irq_out` after the second clock edge.
- R8: Offsets 0x08, 0x0C, 0x24, 0x28 and 0x58 store and return what is written. The value at 0x58 has no effect on any interrupt behaviour.
- R9: Reads of unmapped offsets return 0xFFFFFFFF. So do reads with a size other than 4 or an address not on a word boundary. Writes of any of these kinds change nothing.
- R10: `rsp_valid` is high for exactly the one cycle after each read request. `rsp_rdata` then holds the register value as it stood before the edge that accepted the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 8 | Byte offset |
| acc_size | input | 3 | Access size in bytes; only 4 is honoured |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| sirq_lvl | input | 17 | Level-high serial interrupt lines, line n sets bit 31-n |
| irq_out | output | 1 | Aggregated interrupt, high while master status is nonzero |

## Verification
A wrong latch or clear in either status register shows up on `irq_out` by the second edge after the event. It also reads back wrongly at 0x38 or 0x50 on the cycle after the read request. A summary gated wrongly by the enable bit or the mask shows as a bad bit 11 at 0x5C on the very next read. It also shows as a spurious or missing rise of `irq_out` one edge later. Stored-only registers and the address decode only reveal faults through read-back, so each mapped and unmapped offset is read after a write to it.

// File: rtl/irq_latch_aggr_pkg.sv
package irq_latch_aggr_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  // master-stage offsets
  localparam logic [ADDR_W-1:0] OFS_ROUTE_A = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_B = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_BM_STAT = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_BM_MASK = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_BM_POL  = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_BM_IN   = 8'h5C;

  // host-stage offsets
  localparam logic [ADDR_W-1:0] OFS_FW_WIN  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_FW_RDSZ = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_SER_CTL = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_HC_MASK = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_HC_STAT = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_ERR_ADR = 8'h40;

  localparam logic [REG_W-1:0] FW_RDSZ_RST = 32'h0200_0000;
  localparam logic [REG_W-1:0] UNMAPPED_RD = '1;
  localparam int unsigned      SER_EN_BIT  = 31;
  localparam int unsigned      LINK_BIT    = 11;
  localparam logic [2:0]       WORD_BYTES  = 3'd4;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } reg_wr_t;

endpackage

// File: rtl/irq_acc_front.sv
module irq_acc_front
  import irq_latch_aggr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [REG_W-1:0]  acc_wdata,
  output reg_wr_t           wr,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              host_hit,
  input  logic [REG_W-1:0]  host_data,
  input  logic              bm_hit,
  input  logic [REG_W-1:0]  bm_data,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata
);

  localparam int unsigned ALIGN_W = $clog2(REG_W / 8);

  logic             well_formed;
  logic             rd_req;
  logic [REG_W-1:0] rd_sel;

  assign well_formed = (acc_size == WORD_BYTES) && (acc_addr[ALIGN_W-1:0] == '0);
  assign rd_req      = acc_valid && !acc_write;
  assign rd_addr     = acc_addr;

  always_comb begin
    wr.we   = acc_valid && acc_write && well_formed;
    wr.addr = acc_addr;
    wr.data = acc_wdata;
  end

  always_comb begin
    if (!well_formed)  rd_sel = UNMAPPED_RD;
    else if (host_hit) rd_sel = host_data;
    else if (bm_hit)   rd_sel = bm_data;
    else               rd_sel = UNMAPPED_RD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_sel;
    end
  end

  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size != WORD_BYTES) |=> (rsp_rdata == UNMAPPED_RD)); // R9

endmodule

// File: rtl/irq_host_stage.sv
module irq_host_stage
  import irq_latch_aggr_pkg::*;
#(
  parameter int unsigned SIRQ_N = 17
)(
  input  logic              clk,
  input  logic              rst_n,
  input  reg_wr_t           wr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [REG_W-1:0]  rd_data,
  input  logic [SIRQ_N-1:0] sirq_lvl,
  output logic              summary
);

  localparam int unsigned LOW_BIT = REG_W - SIRQ_N;

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_q, stat_d;
  logic [REG_W-1:0] mask_q, ctrl_q, win_q, rdsz_q;

  // line n lands on bit REG_W-1-n
  for (genvar b = 0; b < REG_W; b++) begin : g_map
    if (b >= LOW_BIT) begin : g_line
      assign set_vec[b] = sirq_lvl[REG_W-1-b];
    end else begin : g_none
      assign set_vec[b] = 1'b0;
    end
  end

  assign clr_vec = (wr.we && wr.addr == OFS_HC_STAT) ? wr.data : '0;
  assign stat_d  = (stat_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      win_q  <= '0;
      rdsz_q <= FW_RDSZ_RST;
    end else begin
      stat_q <= stat_d;
      if (wr.we) begin
        case (wr.addr)
          OFS_HC_MASK: mask_q <= wr.data;
          OFS_SER_CTL: ctrl_q <= wr.data;
          OFS_FW_WIN:  win_q  <= wr.data;
          OFS_FW_RDSZ: rdsz_q <= wr.data;
          default: ;
        endcase
      end
    end
  end

  assign summary = ctrl_q[SER_EN_BIT] && (|(stat_q & mask_q));

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (rd_addr)
      OFS_FW_WIN:  rd_data = win_q;
      OFS_FW_RDSZ: rd_data = rdsz_q;
      OFS_SER_CTL: rd_data = ctrl_q;
      OFS_HC_MASK: rd_data = mask_q;
      OFS_HC_STAT: rd_data = stat_q;
      OFS_ERR_ADR: rd_data = '0;
      default:     rd_hit  = 1'b0;
    endcase
  end

  AST_HC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R2

  AST_HC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec))); // R3

endmodule

// File: rtl/irq_master_stage.sv
module irq_master_stage
  import irq_latch_aggr_pkg::*;
#(
  parameter int unsigned LINK_POS = LINK_BIT
)(
  input  logic              clk,
  input  logic              rst_n,
  input  reg_wr_t           wr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [REG_W-1:0]  rd_data,
  input  logic              link_in,
  output logic              irq_out
);

  logic [REG_W-1:0] in_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_q, stat_d;
  logic [REG_W-1:0] mask_q, pol_q, route_a_q, route_b_q;

  always_comb begin
    in_vec           = '0;
    in_vec[LINK_POS] = link_in;
  end

  assign clr_vec = (wr.we && wr.addr == OFS_BM_STAT) ? wr.data : '0;
  assign stat_d  = (stat_q & ~clr_vec) | (in_vec & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      mask_q    <= '0;
      pol_q     <= '0;
      route_a_q <= '0;
      route_b_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr.we) begin
        case (wr.addr)
          OFS_BM_MASK: mask_q    <= wr.data;
          OFS_BM_POL:  pol_q     <= wr.data;
          OFS_ROUTE_A: route_a_q <= wr.data;
          OFS_ROUTE_B: route_b_q <= wr.data;
          default: ;
        endcase
      end
    end
  end

  assign irq_out = |stat_q;

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (rd_addr)
      OFS_ROUTE_A: rd_data = route_a_q;
      OFS_ROUTE_B: rd_data = route_b_q;
      OFS_BM_STAT: rd_data = stat_q;
      OFS_BM_MASK: rd_data = mask_q;
      OFS_BM_POL:  rd_data = pol_q;
      OFS_BM_IN:   rd_data = in_vec;
      default:     rd_hit  = 1'b0;
    endcase
  end

  AST_BM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(in_vec & mask_q)) == $past(in_vec & mask_q))); // R6

  AST_BM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec))); // R6

endmodule

// File: rtl/irq_latch_aggr.sv
module irq_latch_aggr
  import irq_latch_aggr_pkg::*;
#(
  parameter int unsigned SIRQ_N = 17
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [7:0]        acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [SIRQ_N-1:0] sirq_lvl,
  output logic              irq_out
);

  reg_wr_t           wr;
  logic [ADDR_W-1:0] rd_addr;
  logic              host_hit, bm_hit;
  logic [REG_W-1:0]  host_data, bm_data;
  logic              host_summary;

  irq_acc_front u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .wr        (wr),
    .rd_addr   (rd_addr),
    .host_hit  (host_hit),
    .host_data (host_data),
    .bm_hit    (bm_hit),
    .bm_data   (bm_data),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  irq_host_stage #(.SIRQ_N(SIRQ_N)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .rd_addr  (rd_addr),
    .rd_hit   (host_hit),
    .rd_data  (host_data),
    .sirq_lvl (sirq_lvl),
    .summary  (host_summary)
  );

  irq_master_stage #(.LINK_POS(LINK_BIT)) u_bm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr),
    .rd_addr (rd_addr),
    .rd_hit  (bm_hit),
    .rd_data (bm_data),
    .link_in (host_summary),
    .irq_out (irq_out)
  );

  AST_IRQ_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(host_summary)); // R7

endmodule

// File: tb/irq_latch_aggr_test.sv
`timescale 1ns/1ps
module irq_latch_aggr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [2:0]  acc_size = 3'd4;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [16:0] sirq_lvl = '0;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_latch_aggr uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sirq_lvl(sirq_lvl),
    .irq_out(irq_out)
  );

  // {addr, do_write, wdata, expected read}
  localparam logic [72:0] VEC [0:11] = '{
    {8'h28, 1'b0, 32'h0000_0000, 32'h0200_0000}, // R1
    {8'h30, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R1
    {8'h24, 1'b1, 32'h1234_5678, 32'h1234_5678}, // R8
    {8'h28, 1'b1, 32'h0700_0000, 32'h0700_0000}, // R8
    {8'h08, 1'b1, 32'hA5A5_0001, 32'hA5A5_0001}, // R8
    {8'h0C, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF}, // R8
    {8'h58, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R8
    {8'h10, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF}, // R9
    {8'h10, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF}, // R9
    {8'h40, 1'b1, 32'h0000_DEAD, 32'h0000_0000}, // R5
    {8'h5C, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R5
    {8'h3C, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // callers are aligned to a negedge
  task automatic wr32(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; acc_size = sz;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_size = 3'd4;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] v, input logic [2:0] sz = 3'd4);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0; acc_size = 3'd4;
    check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    v = rsp_rdata;
  endtask

  task automatic pulse_line(input int n);
    sirq_lvl = 17'd1 << n;
    @(posedge clk); @(negedge clk);
    sirq_lvl = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq_out after reset", {31'd0, irq_out}, 32'd0);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    rd32(8'h50, v); check("R1 master status reset", v, 32'h0);

    foreach (VEC[i]) begin
      if (VEC[i][64]) begin
        wr32(VEC[i][72:65], VEC[i][63:32]);
        check("R10 no response after write", {31'd0, rsp_valid}, 32'd0);
      end
      rd32(VEC[i][72:65], v);
      check($sformatf("R1/R5/R8/R9 table row %0d", i), v, VEC[i][31:0]);
    end

    // line 2 through both stages
    wr32(8'h30, 32'h8000_0000);
    wr32(8'h34, 32'h2000_0000);
    wr32(8'h54, 32'h0000_0800);
    sirq_lvl = 17'd1 << 2;
    @(posedge clk); @(negedge clk);
    sirq_lvl = '0;
    check("R7 irq_out one edge after event", {31'd0, irq_out}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R7 irq_out two edges after event", {31'd0, irq_out}, 32'd1);
    rd32(8'h38, v); check("R2 line 2 sticky bit 29", v, 32'h2000_0000);
    rd32(8'h5C, v); check("R4 summary on input bit 11", v, 32'h0000_0800);
    rd32(8'h50, v); check("R6 master status latched", v, 32'h0000_0800);

    // clear master while host still pending: re-set
    wr32(8'h50, 32'h0000_0800);
    rd32(8'h50, v); check("R6 re-set while input high", v, 32'h0000_0800);

    // clear host: master stays sticky
    wr32(8'h38, 32'h2000_0000);
    rd32(8'h5C, v); check("R4 summary drops after clear", v, 32'h0);
    rd32(8'h50, v); check("R6 sticky after input drop", v, 32'h0000_0800);
    check("R7 irq_out held", {31'd0, irq_out}, 32'd1);
    wr32(8'h50, 32'h0000_0800);
    rd32(8'h50, v); check("R6 W1C master", v, 32'h0);
    check("R7 irq_out low after clear", {31'd0, irq_out}, 32'd0);

    // enable gate with line 16
    wr32(8'h30, 32'h0);
    wr32(8'h34, 32'hFFFF_8000);
    pulse_line(16);
    rd32(8'h38, v); check("R2 line 16 sets bit 15", v, 32'h0000_8000);
    rd32(8'h5C, v); check("R4 gated by enable", v, 32'h0);
    check("R7 irq_out gated", {31'd0, irq_out}, 32'd0);
    wr32(8'h30, 32'h8000_0000);
    rd32(8'h5C, v); check("R4 summary after enable", v, 32'h0000_0800);
    check("R7 irq_out after enable", {31'd0, irq_out}, 32'd1);

    // set beats clear in the same cycle, partial clear
    sirq_lvl = 17'd1;
    wr32(8'h38, 32'h8000_0000);
    sirq_lvl = '0;
    rd32(8'h38, v); check("R3 set wins over clear", v, 32'h8000_8000);
    wr32(8'h38, 32'h0000_8000);
    rd32(8'h38, v); check("R3 clears only ones", v, 32'h8000_0000);

    // master mask zero, polarity all ones has no effect
    wr32(8'h54, 32'h0);
    wr32(8'h50, 32'hFFFF_FFFF);
    rd32(8'h50, v); check("R6 masked input not latched", v, 32'h0);
    check("R7/R8 irq_out low, polarity ignored", {31'd0, irq_out}, 32'd0);
    rd32(8'h5C, v); check("R4 input still shows summary", v, 32'h0000_0800);

    // access size and alignment
    wr32(8'h24, 32'h0, 3'd1);
    rd32(8'h24, v); check("R9 byte write ignored", v, 32'h1234_5678);
    rd32(8'h24, v, 3'd2); check("R9 half read all ones", v, 32'hFFFF_FFFF);
    rd32(8'h25, v); check("R9 unaligned read all ones", v, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule